// File: doc/BRIEF.md
# Incremental Pulse Write-Verify Controller

This block programs one resistive memory cell to a three-level target value. It first drives the cell to its high-resistance state. It then raises the cell's conductance step by step, applying a program pulse and reading the cell back after each pulse, until the read current meets the threshold for the requested level. Each step has its own amplitude code and its own pulse width. These come from two small step tables, one for the reset phase and one for the set phase, which are loaded through a simple write port.

Two ways of entering the high-resistance state can be chosen for each write. The first applies one reset pulse and moves straight to the set loop. The second repeats reset pulses, each followed by a verify read, until the read current is low enough. The controller drives a polarity select, which tells the analog drivers whether the drain terminal (set) or the source terminal (reset) is pulsed. It talks to the sense path through a request/valid handshake. When a write ends, it reports success or failure and the number of pulses it used in each phase.

Top module: `rram_wv_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy, pulse_on, vfy_req, done and fail are 0, pulse_amp is 0, and both iteration counts are 0.
- R2: A start sampled while the block is idle begins a write. busy is 1 from the next cycle until the write ends. A start sampled while busy is ignored and does not change the write in progress.
- R3: Step k of a phase drives pulse_on high for exactly width[k]+1 consecutive cycles, with pulse_amp equal to amp[k] of that phase's table. pulse_amp is 0 whenever pulse_on is 0. One idle cycle comes before each pulse.
- R4: vfy_req rises only after pulse_on has been low for one full cycle. It stays high until vfy_valid is sampled.
- R5: A reset-phase verify passes when vfy_current <= thr_reset. A set-phase verify passes when vfy_current >= thr_lvl1 for target 1, or when vfy_current >= thr_lvl2 for targets 2 and 3.
- R6: With init_mode = 0, the reset phase is one reset pulse with no verify read. With init_mode = 1, reset pulses and verify reads repeat until a verify passes.
- R7: Target 0 ends the write with done = 1 as soon as the reset phase completes. No set pulse is issued.
- R8: pol_set is 0 throughout the reset phase and 1 throughout the set phase.
- R9: If the verify read after the last step (step 15 of 16) of a phase fails, the write ends with fail = 1 and done = 0.
- R10: rst_iters and set_iters give the number of reset and set pulses issued by the last write. They and done/fail hold their values until the next accepted start.
- R11: The set phase begins at step 0 of the set table, no matter how many reset steps were used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a write when idle |
| target | input | 2 | Target level 0..2 (3 acts as 2) |
| init_mode | input | 1 | 0: single reset pulse, 1: iterated reset with verify |
| thr_reset | input | CUR_W | Reset-phase pass threshold (current at or below) |
| thr_lvl1 | input | CUR_W | Set-phase pass threshold for level 1 |
| thr_lvl2 | input | CUR_W | Set-phase pass threshold for level 2 |
| cfg_we | input | 1 | Step table write enable |
| cfg_set | input | 1 | Table select: 1 set table, 0 reset table |
| cfg_idx | input | log2(STEPS) | Step index to write |
| cfg_amp | input | AMP_W | Amplitude code for the step |
| cfg_width | input | WID_W | Pulse width minus one, in cycles |
| vfy_valid | input | 1 | Verify result valid |
| vfy_current | input | CUR_W | Read current code from the sense path |
| busy | output | 1 | Write in progress |
| pulse_on | output | 1 | Program pulse active |
| pulse_amp | output | AMP_W | Amplitude code of the active pulse |
| pol_set | output | 1 | 1: drive drain (set), 0: drive source (reset) |
| vfy_req | output | 1 | Verify read request |
| done | output | 1 | Last write reached its target |
| fail | output | 1 | Last write ran out of steps |
| rst_iters | output | log2(STEPS+1) | Reset pulses used by last write |
| set_iters | output | log2(STEPS+1) | Set pulses used by last write |

## Verification
Two events can meet in one cycle: the verify result that ends a write and a new start request. The bench provokes this by raising start, with a different target, in the same cycle that it returns the final verify result. The cycle-accurate expected trace must then show the block going idle with the original write's status and counts, and no second write. Threshold equality is also tested at both comparators, and a full 16-step exhaustion is run in each phase.

// File: rtl/rram_wv_pkg.sv
package rram_wv_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ISSUE  = 3'd1,
    S_PULSE  = 3'd2,
    S_GAP    = 3'd3,
    S_VERIFY = 3'd4
  } wv_state_e;
endpackage

// File: rtl/wv_step_table.sv
module wv_step_table #(
  parameter int STEPS = 16,
  parameter int AMP_W = 8,
  parameter int WID_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(STEPS)-1:0] widx,
  input  logic [AMP_W-1:0]         wamp,
  input  logic [WID_W-1:0]         wwid,
  input  logic [$clog2(STEPS)-1:0] ridx,
  output logic [AMP_W-1:0]         ramp,
  output logic [WID_W-1:0]         rwid
);
  logic [AMP_W-1:0] amp_mem [STEPS];
  logic [WID_W-1:0] wid_mem [STEPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STEPS; i++) begin
        amp_mem[i] <= '0;
        wid_mem[i] <= '0;
      end
    end else if (we) begin
      amp_mem[widx] <= wamp;
      wid_mem[widx] <= wwid;
    end
  end

  assign ramp = amp_mem[ridx];
  assign rwid = wid_mem[ridx];
endmodule

// File: rtl/wv_verify_judge.sv
module wv_verify_judge #(
  parameter int CUR_W = 8
) (
  input  logic             phase_set,
  input  logic [1:0]       tgt,
  input  logic [CUR_W-1:0] cur,
  input  logic [CUR_W-1:0] thr_reset,
  input  logic [CUR_W-1:0] thr_lvl1,
  input  logic [CUR_W-1:0] thr_lvl2,
  output logic             pass
);
  always_comb begin
    if (!phase_set) begin
      pass = (cur <= thr_reset);
    end else if (tgt == 2'd1) begin
      pass = (cur >= thr_lvl1);
    end else begin
      pass = (cur >= thr_lvl2);
    end
  end
endmodule

// File: rtl/wv_seq_fsm.sv
module wv_seq_fsm
  import rram_wv_pkg::*;
#(
  parameter int STEPS = 16,
  parameter int AMP_W = 8,
  parameter int WID_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 target,
  input  logic                       init_mode,
  input  logic [AMP_W-1:0]           tbl_amp,
  input  logic [WID_W-1:0]           tbl_wid,
  input  logic                       vfy_valid,
  input  logic                       vfy_pass,
  output logic [$clog2(STEPS)-1:0]   step_idx,
  output logic                       phase_set,
  output logic [1:0]                 tgt,
  output logic                       busy,
  output logic                       pulse_on,
  output logic [AMP_W-1:0]           pulse_amp,
  output logic                       vfy_req,
  output logic                       done,
  output logic                       fail,
  output logic [$clog2(STEPS+1)-1:0] rst_iters,
  output logic [$clog2(STEPS+1)-1:0] set_iters
);
  localparam int IDX_W = $clog2(STEPS);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  wv_state_e        state_q, state_d;
  logic             phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WID_W-1:0] wcnt_q, wcnt_d;
  logic [AMP_W-1:0] amp_q, amp_d;
  logic [1:0]       tgt_q, tgt_d;
  logic             mode_q, mode_d;
  logic             done_q, done_d;
  logic             fail_q, fail_d;
  logic [CNT_W-1:0] rcnt_q, rcnt_d;
  logic [CNT_W-1:0] scnt_q, scnt_d;
  logic             leave_reset;

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    idx_d       = idx_q;
    wcnt_d      = wcnt_q;
    amp_d       = amp_q;
    tgt_d       = tgt_q;
    mode_d      = mode_q;
    done_d      = done_q;
    fail_d      = fail_q;
    rcnt_d      = rcnt_q;
    scnt_d      = scnt_q;
    leave_reset = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          tgt_d   = target;
          mode_d  = init_mode;
          phase_d = 1'b0;
          idx_d   = '0;
          done_d  = 1'b0;
          fail_d  = 1'b0;
          rcnt_d  = '0;
          scnt_d  = '0;
          state_d = S_ISSUE;
        end
      end
      S_ISSUE: begin
        amp_d  = tbl_amp;
        wcnt_d = tbl_wid;
        if (phase_q) scnt_d = scnt_q + CNT_W'(1);
        else         rcnt_d = rcnt_q + CNT_W'(1);
        state_d = S_PULSE;
      end
      S_PULSE: begin
        if (wcnt_q == '0) state_d = S_GAP;
        else              wcnt_d  = wcnt_q - WID_W'(1);
      end
      S_GAP: begin
        if (!phase_q && !mode_q) leave_reset = 1'b1;
        else                     state_d     = S_VERIFY;
      end
      S_VERIFY: begin
        if (vfy_valid) begin
          if (vfy_pass) begin
            if (!phase_q) begin
              leave_reset = 1'b1;
            end else begin
              done_d  = 1'b1;
              state_d = S_IDLE;
            end
          end else if (idx_q == LAST_IDX) begin
            fail_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = S_ISSUE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (leave_reset) begin
      if (tgt_q == 2'd0) begin
        done_d  = 1'b1;
        state_d = S_IDLE;
      end else begin
        phase_d = 1'b1;
        idx_d   = '0;
        state_d = S_ISSUE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= 1'b0;
      idx_q   <= '0;
      wcnt_q  <= '0;
      amp_q   <= '0;
      tgt_q   <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      rcnt_q  <= '0;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      wcnt_q  <= wcnt_d;
      amp_q   <= amp_d;
      tgt_q   <= tgt_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      rcnt_q  <= rcnt_d;
      scnt_q  <= scnt_d;
    end
  end

  assign step_idx  = idx_q;
  assign phase_set = phase_q;
  assign tgt       = tgt_q;
  assign busy      = (state_q != S_IDLE);
  assign pulse_on  = (state_q == S_PULSE);
  assign pulse_amp = (state_q == S_PULSE) ? amp_q : '0;
  assign vfy_req   = (state_q == S_VERIFY);
  assign done      = done_q;
  assign fail      = fail_q;
  assign rst_iters = rcnt_q;
  assign set_iters = scnt_q;
endmodule

// File: rtl/rram_wv_ctrl.sv
module rram_wv_ctrl #(
  parameter int STEPS = 16,
  parameter int AMP_W = 8,
  parameter int WID_W = 6,
  parameter int CUR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 target,
  input  logic                       init_mode,
  input  logic [CUR_W-1:0]           thr_reset,
  input  logic [CUR_W-1:0]           thr_lvl1,
  input  logic [CUR_W-1:0]           thr_lvl2,
  input  logic                       cfg_we,
  input  logic                       cfg_set,
  input  logic [$clog2(STEPS)-1:0]   cfg_idx,
  input  logic [AMP_W-1:0]           cfg_amp,
  input  logic [WID_W-1:0]           cfg_width,
  input  logic                       vfy_valid,
  input  logic [CUR_W-1:0]           vfy_current,
  output logic                       busy,
  output logic                       pulse_on,
  output logic [AMP_W-1:0]           pulse_amp,
  output logic                       pol_set,
  output logic                       vfy_req,
  output logic                       done,
  output logic                       fail,
  output logic [$clog2(STEPS+1)-1:0] rst_iters,
  output logic [$clog2(STEPS+1)-1:0] set_iters
);
  localparam int IDX_W = $clog2(STEPS);
  localparam int NPH   = 2;

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [AMP_W-1:0] amp_arr [NPH];
  logic [WID_W-1:0] wid_arr [NPH];
  logic [IDX_W-1:0] step_idx;
  logic             phase_set;
  logic [1:0]       tgt;
  logic             vfy_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  for (genvar p = 0; p < NPH; p++) begin : g_tbl
    wv_step_table #(.STEPS(STEPS), .AMP_W(AMP_W), .WID_W(WID_W)) u_tbl (
      .clk  (clk),
      .rst_n(rst_int_n),
      .we   (cfg_we && (cfg_set == 1'(p))),
      .widx (cfg_idx),
      .wamp (cfg_amp),
      .wwid (cfg_width),
      .ridx (step_idx),
      .ramp (amp_arr[p]),
      .rwid (wid_arr[p])
    );
  end

  wv_verify_judge #(.CUR_W(CUR_W)) u_judge (
    .phase_set(phase_set),
    .tgt      (tgt),
    .cur      (vfy_current),
    .thr_reset(thr_reset),
    .thr_lvl1 (thr_lvl1),
    .thr_lvl2 (thr_lvl2),
    .pass     (vfy_pass)
  );

  wv_seq_fsm #(.STEPS(STEPS), .AMP_W(AMP_W), .WID_W(WID_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .target   (target),
    .init_mode(init_mode),
    .tbl_amp  (amp_arr[phase_set]),
    .tbl_wid  (wid_arr[phase_set]),
    .vfy_valid(vfy_valid),
    .vfy_pass (vfy_pass),
    .step_idx (step_idx),
    .phase_set(phase_set),
    .tgt      (tgt),
    .busy     (busy),
    .pulse_on (pulse_on),
    .pulse_amp(pulse_amp),
    .vfy_req  (vfy_req),
    .done     (done),
    .fail     (fail),
    .rst_iters(rst_iters),
    .set_iters(set_iters)
  );

  assign pol_set = phase_set;
endmodule

// File: rtl/rram_wv_ctrl_chk.sv
module rram_wv_ctrl_chk #(
  parameter int STEPS = 16,
  parameter int AMP_W = 8,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             pulse_on,
  input logic [AMP_W-1:0] pulse_amp,
  input logic             pol_set,
  input logic             vfy_req,
  input logic             vfy_valid,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] rst_iters,
  input logic [CNT_W-1:0] set_iters
);
  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pulse_on && !vfy_req));

  p_pulse_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_on && $past(pulse_on)) |-> ($stable(pulse_amp) && $stable(pol_set)));

  p_req_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vfy_req) |-> (!pulse_on && !$past(pulse_on)));

  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_req && !vfy_valid) |=> vfy_req);

  p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rst_iters) <= STEPS) && (32'(set_iters) <= STEPS));

  p_status_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);
endmodule

bind rram_wv_ctrl rram_wv_ctrl_chk #(
  .STEPS(STEPS), .AMP_W(AMP_W), .CNT_W($clog2(STEPS+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pulse_on(pulse_on),
  .pulse_amp(pulse_amp), .pol_set(pol_set), .vfy_req(vfy_req),
  .vfy_valid(vfy_valid), .done(done), .fail(fail),
  .rst_iters(rst_iters), .set_iters(set_iters)
);

// File: tb/rram_wv_ctrl_tb.sv
module rram_wv_ctrl_tb;
  localparam int STEPS = 16;
  localparam int AMP_W = 8;
  localparam int WID_W = 6;
  localparam int CUR_W = 8;
  localparam int CNT_W = $clog2(STEPS+1);
  localparam int LAT   = 2;
  localparam int THR_R = 50;
  localparam int THR_1 = 80;
  localparam int THR_2 = 170;

  logic clk, rst_n, start, init_mode, cfg_we, cfg_set, vfy_valid;
  logic [1:0] target;
  logic [CUR_W-1:0] thr_reset, thr_lvl1, thr_lvl2, vfy_current;
  logic [3:0] cfg_idx;
  logic [AMP_W-1:0] cfg_amp, pulse_amp;
  logic [WID_W-1:0] cfg_width;
  logic busy, pulse_on, pol_set, vfy_req, done, fail;
  logic [CNT_W-1:0] rst_iters, set_iters;

  rram_wv_ctrl u_dut (.*);

  typedef struct packed { logic p; logic [7:0] a; logic pol; logic req; } ent_t;
  ent_t exp_q[$];
  int resp_q[$];
  int rc_q[$];
  int sc_q[$];
  int r_amp[16], r_wid[16], s_amp[16], s_wid[16];
  int e_rst, e_set, e_done, e_fail;
  int total = 0, bad = 0, cyc = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, ex);
    end
  endtask

  task automatic add_pulse(input int amp, input int wid, input bit pol);
    exp_q.push_back('{p:1'b0, a:8'd0, pol:pol, req:1'b0});
    for (int i = 0; i <= wid; i++) exp_q.push_back('{p:1'b1, a:8'(amp), pol:pol, req:1'b0});
    exp_q.push_back('{p:1'b0, a:8'd0, pol:pol, req:1'b0});
  endtask

  task automatic add_verify(input bit pol, input int cur);
    resp_q.push_back(cur);
    for (int i = 0; i <= LAT; i++) exp_q.push_back('{p:1'b0, a:8'd0, pol:pol, req:1'b1});
  endtask

  // Reference: trace from the requirements (R3, R4, R5, R6, R7, R8, R9, R11)
  task automatic plan_write(input int tgt, input bit mode);
    bit passed;
    int thr;
    exp_q.delete(); resp_q.delete();
    e_rst = 0; e_set = 0; e_done = 0; e_fail = 0;
    passed = 0;
    for (int k = 0; k < STEPS && !passed; k++) begin
      add_pulse(r_amp[k], r_wid[k], 1'b0);
      e_rst++;
      if (!mode) passed = 1;
      else begin
        add_verify(1'b0, rc_q[k]);
        if (rc_q[k] <= THR_R) passed = 1;
      end
    end
    if (!passed) begin e_fail = 1; return; end
    if (tgt == 0) begin e_done = 1; return; end
    thr = (tgt == 1) ? THR_1 : THR_2;
    passed = 0;
    for (int k = 0; k < STEPS && !passed; k++) begin
      add_pulse(s_amp[k], s_wid[k], 1'b1);
      e_set++;
      add_verify(1'b1, sc_q[k]);
      if (sc_q[k] >= thr) passed = 1;
    end
    if (passed) e_done = 1; else e_fail = 1;
  endtask

  task automatic run_write(input int tgt, input bit mode, input bit restart);
    ent_t e;
    int rcnt;
    plan_write(tgt, mode);
    rcnt = 0;
    @(negedge clk);
    start = 1'b1; target = 2'(tgt); init_mode = mode;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      start = 1'b0;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(busy == 1'b1, "R2 busy", busy, 1);
        chk(pulse_on == e.p, "R3 pulse_on", pulse_on, e.p);
        chk(pulse_amp == e.a, "R3 pulse_amp", pulse_amp, e.a);
        chk(vfy_req == e.req, "R4 vfy_req", vfy_req, e.req);
        chk(pol_set == e.pol, "R8 pol_set", pol_set, e.pol);
      end else begin
        chk(busy == 1'b0, "R2 idle at end", busy, 0);
        chk(done == e_done[0], "R7 done", done, e_done);
        chk(fail == e_fail[0], "R9 fail", fail, e_fail);
        chk(rst_iters == CNT_W'(e_rst), "R10 rst_iters", rst_iters, e_rst);
        chk(set_iters == CNT_W'(e_set), "R10 set_iters", set_iters, e_set);
        break;
      end
      if (vfy_req) begin
        rcnt++;
        if (rcnt == LAT + 1) begin
          rcnt = 0;
          vfy_valid = 1'b1;
          vfy_current = CUR_W'(resp_q.pop_front());
          if (restart && resp_q.size() == 0) begin
            start = 1'b1; target = 2'd0; init_mode = ~mode;
          end
        end else vfy_valid = 1'b0;
      end else begin
        rcnt = 0;
        vfy_valid = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 no second write", busy, 0);
    chk(done == e_done[0], "R10 done held", done, e_done);
    chk(rst_iters == CNT_W'(e_rst), "R10 rst_iters held", rst_iters, e_rst);
  endtask

  task automatic cfg_write(input bit set_tbl, input int idx, input int amp, input int wid);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = set_tbl; cfg_idx = 4'(idx);
    cfg_amp = AMP_W'(amp); cfg_width = WID_W'(wid);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; target = 2'd0; init_mode = 1'b0;
    cfg_we = 1'b0; cfg_set = 1'b0; cfg_idx = '0; cfg_amp = '0; cfg_width = '0;
    vfy_valid = 1'b0; vfy_current = '0;
    thr_reset = CUR_W'(THR_R); thr_lvl1 = CUR_W'(THR_1); thr_lvl2 = CUR_W'(THR_2);
    repeat (3) @(negedge clk);
    chk(busy == 0 && pulse_on == 0 && vfy_req == 0, "R1 reset outputs", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 0 && fail == 0 && pulse_amp == 0, "R1 status after reset", done, 0);
    chk(rst_iters == 0 && set_iters == 0, "R1 counts after reset", rst_iters, 0);

    for (int i = 0; i < STEPS; i++) begin
      r_amp[i] = 10 + 3 * i; r_wid[i] = i % 3;
      s_amp[i] = 20 + 5 * i; s_wid[i] = (i + 1) % 4;
      cfg_write(1'b0, i, r_amp[i], r_wid[i]);
      cfg_write(1'b1, i, s_amp[i], s_wid[i]);
    end

    // R6 iterated reset, R11 set restarts at step 0, R5 level-2 threshold
    rc_q = '{200, 150, 30}; sc_q = '{10, 100, 180};
    run_write(2, 1'b1, 1'b0);
    // R6 single reset pulse, R5 level-1 threshold equality (80 passes)
    rc_q = '{}; sc_q = '{79, 80};
    run_write(1, 1'b0, 1'b0);
    // R7 target 0 after single reset pulse
    run_write(0, 1'b0, 1'b0);
    // R7 target 0 with iterated reset, R5 reset equality (50 passes)
    rc_q = '{51, 50};
    run_write(0, 1'b1, 1'b0);
    // R5 target 3 uses level-2 threshold (169 fails, 170 passes)
    rc_q = '{0}; sc_q = '{169, 170};
    run_write(3, 1'b1, 1'b0);
    // R9 set-phase exhaustion after 16 steps
    rc_q = '{0}; sc_q.delete();
    for (int i = 0; i < STEPS; i++) sc_q.push_back(5);
    run_write(1, 1'b1, 1'b0);
    // R9 reset-phase exhaustion
    rc_q.delete();
    for (int i = 0; i < STEPS; i++) rc_q.push_back(255);
    run_write(2, 1'b1, 1'b0);
    // R2 start in the same cycle as the final verify result is ignored
    rc_q = '{10}; sc_q = '{90, 200};
    run_write(2, 1'b1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule